// File: doc/BRIEF.md
# Oversampling Filtered Serial Byte Receiver

This block turns an asynchronous serial line into bytes. A phase-accumulator rate generator makes a tick at eight times the bit rate. The line passes through a two-stage synchronizer that stores it inverted. As a result, the idle (mark) level reads as 0 internally, and the synchronizer resets to that idle value. A two-bit saturating counter, stepped on every tick, removes short spikes. Only the counter's output, the filtered level, is used to find start bits.

A rising edge of the filtered level (a fresh space) starts a frame. A phase counter then gives a bit strobe four ticks later and every eight ticks after that, so each bit is sampled near the middle of its filtered window. Data arrives least significant bit first into a shift register. A mark in the stop bit delivers the byte with a one-cycle valid pulse. A space in the stop bit drops the byte and pulses a framing-error flag instead. An end-of-packet pulse marks a quiet line that follows at least one good byte.

Top module: `orx_uart_rx`

## Requirements
- R1: While reset is held, and after it is released with the line idle, rx_byte reads 0 and byte_valid, frame_err and pkt_end stay 0. The synchronizer resets to the idle level, so no false character appears.
- R2: The rate generator adds round(BAUD*8*2^ACC_W/CLK_HZ) per clock and ticks on carry. Eight ticks make one bit time. With the defaults (200 MHz, 6.25 Mbit/s, ACC_W=8) this gives a tick every 4 clocks and a bit time of 32 clocks.
- R3: A space must be seen on 3 consecutive ticks before the filtered level changes. A space pulse spanning at most 2 ticks causes no output, and a byte sent after it is received intact.
- R4: A space that passes the filter but is gone when the start bit is re-checked, 4 ticks after detection, is treated as a false start. It produces no output and does not disturb the next byte.
- R5: Line level 1 is mark and 0 is space. A data bit equals the line level. Bits arrive LSB first after one space start bit, followed by one stop bit.
- R6: byte_valid is high for exactly one clock per good frame, with rx_byte holding the new byte in that same cycle. rx_byte changes at no other time.
- R7: If the stop bit reads as a space, frame_err pulses for one clock, byte_valid stays 0 and rx_byte keeps its previous value.
- R8: After a framing error with the line held at space (a break), no further frame starts until the line has returned to mark. A long break gives exactly one frame_err.
- R9: pkt_end pulses for one clock once the filtered line has been idle for GAP_BITS*8 ticks after a good byte. It fires once per quiet spell and never during a gap shorter than that.
- R10: A quiet spell that follows only errored frames, with no good byte since the last pkt_end, gives no pkt_end.
- R11: Frames sent back to back, with the next start bit directly after the stop bit, are all received without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Asynchronous serial line, 1 = mark |
| rx_byte | output | DATA_W | Last good byte received |
| byte_valid | output | 1 | One-cycle pulse: rx_byte holds a new byte |
| frame_err | output | 1 | One-cycle pulse: stop bit read as space, byte dropped |
| pkt_end | output | 1 | One-cycle pulse: quiet line after received bytes |

## Verification
The quiet-line timer competes with start detection. If a new start bit arrives just as the idle count nears its limit, the timer is cleared and pkt_end must not appear. The bench provokes this by sweeping back-to-back frames and one-bit gaps, both well under the two-bit limit, and then a long quiet spell. It judges pkt_end by its presence count and by the integrity of the byte that follows. The stop-bit decision splits into either the valid pulse or the error flag. Good, errored and break frames are mixed, and the bench confirms that the two pulses never coincide and that rx_byte holds across errors.

// File: rtl/orx_uart_rx_pkg.sv
package orx_uart_rx_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_START = 2'd1,
    S_DATA  = 2'd2,
    S_STOP  = 2'd3
  } orx_state_e;

  localparam int FLT_W   = 2;
  localparam int FLT_TOP = (1 << FLT_W) - 1;

  // Rounded accumulator increment for an oversampled tick rate.
  function automatic longint orx_acc_inc(input longint clk_hz, input longint baud,
                                         input int ovs, input int acc_w);
    longint num;
    num = (baud * longint'(ovs)) << acc_w;
    return (num + clk_hz / 2) / clk_hz;
  endfunction

  // Saturating step of the spike-filter counter.
  function automatic logic [FLT_W-1:0] orx_flt_step(input logic [FLT_W-1:0] cnt,
                                                    input logic smp);
    if (smp)
      return (cnt == FLT_W'(FLT_TOP)) ? cnt : cnt + 1'b1;
    else
      return (cnt == '0) ? cnt : cnt - 1'b1;
  endfunction

endpackage

// File: rtl/orx_tick_gen.sv
module orx_tick_gen #(
  parameter longint CLK_HZ = 200_000_000,
  parameter longint BAUD   = 6_250_000,
  parameter int     OVS    = 8,
  parameter int     ACC_W  = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  import orx_uart_rx_pkg::*;

  localparam longint INC_L = orx_acc_inc(CLK_HZ, BAUD, OVS, ACC_W);
  localparam logic [ACC_W:0] INC = (ACC_W+1)'(INC_L);

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc} + INC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      acc  <= sum[ACC_W-1:0];
      tick <= sum[ACC_W];
    end
  end
endmodule

// File: rtl/orx_line_front.sv
module orx_line_front (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  output logic sync_bit,
  output logic filt
);
  import orx_uart_rx_pkg::*;

  logic             meta_q;
  logic [FLT_W-1:0] cnt;
  logic [FLT_W-1:0] cnt_nx;

  // Two-stage synchronizer, stored inverted: idle mark reads 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= 1'b0;
      sync_bit <= 1'b0;
    end else begin
      meta_q   <= ~rxd;
      sync_bit <= meta_q;
    end
  end

  assign cnt_nx = orx_flt_step(cnt, sync_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      filt <= 1'b0;
    end else if (tick) begin
      cnt <= cnt_nx;
      if (cnt_nx == FLT_W'(FLT_TOP))
        filt <= 1'b1;
      else if (cnt_nx == '0)
        filt <= 1'b0;
    end
  end
endmodule

// File: rtl/orx_frame_fsm.sv
module orx_frame_fsm #(
  parameter int OVS    = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              filt,
  output logic              start_seen,
  output logic              in_idle,
  output logic [DATA_W-1:0] rx_byte,
  output logic              byte_valid,
  output logic              frame_err
);
  import orx_uart_rx_pkg::*;

  localparam int PH_W = $clog2(OVS);
  localparam int BI_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [PH_W-1:0] MID  = PH_W'(OVS / 2 - 1);
  localparam logic [BI_W-1:0] LAST = BI_W'(DATA_W - 1);

  orx_state_e        state;
  logic [PH_W-1:0]   ph;
  logic [BI_W-1:0]   bidx;
  logic [DATA_W-1:0] shreg;
  logic              filt_prev;
  logic              mid_hit;

  function automatic logic [DATA_W-1:0] push_lsb_first(input logic [DATA_W-1:0] cur,
                                                       input logic bitv);
    return {bitv, cur[DATA_W-1:1]};
  endfunction

  assign in_idle    = (state == S_IDLE);
  assign start_seen = tick && in_idle && filt && !filt_prev;
  assign mid_hit    = tick && !in_idle && (ph == MID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      ph         <= '0;
      bidx       <= '0;
      shreg      <= '0;
      rx_byte    <= '0;
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
      filt_prev  <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
      if (tick) begin
        filt_prev <= filt;
        if (in_idle) begin
          if (start_seen) begin
            state <= S_START;
            ph    <= '0;
          end
        end else begin
          ph <= ph + 1'b1;
          if (mid_hit) begin
            case (state)
              S_START: begin
                if (filt) begin
                  state <= S_DATA;
                  bidx  <= '0;
                end else begin
                  state <= S_IDLE;
                end
              end
              S_DATA: begin
                shreg <= push_lsb_first(shreg, ~filt);
                if (bidx == LAST) state <= S_STOP;
                else              bidx  <= bidx + 1'b1;
              end
              S_STOP: begin
                state <= S_IDLE;
                if (!filt) begin
                  rx_byte    <= shreg;
                  byte_valid <= 1'b1;
                end else begin
                  frame_err  <= 1'b1;
                end
              end
              default: state <= S_IDLE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/orx_gap_timer.sv
module orx_gap_timer #(
  parameter int OVS      = 8,
  parameter int GAP_BITS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic in_idle,
  input  logic filt,
  input  logic start_seen,
  input  logic byte_valid,
  output logic pkt_end
);
  localparam int GAP_TICKS = GAP_BITS * OVS;
  localparam int CW        = $clog2(GAP_TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(GAP_TICKS - 1);

  logic          armed;
  logic [CW-1:0] gcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      gcnt    <= '0;
      pkt_end <= 1'b0;
    end else begin
      pkt_end <= 1'b0;
      if (byte_valid) begin
        armed <= 1'b1;
        gcnt  <= '0;
      end else if (tick && in_idle) begin
        if (start_seen) begin
          gcnt <= '0;
        end else if (armed && !filt) begin
          if (gcnt == LIM) begin
            pkt_end <= 1'b1;
            armed   <= 1'b0;
            gcnt    <= '0;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/orx_uart_rx.sv
module orx_uart_rx #(
  parameter longint CLK_HZ   = 200_000_000,
  parameter longint BAUD     = 6_250_000,
  parameter int     ACC_W    = 8,
  parameter int     OVS      = 8,
  parameter int     DATA_W   = 8,
  parameter int     GAP_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_byte,
  output logic              byte_valid,
  output logic              frame_err,
  output logic              pkt_end
);
  // Internal events brought out as named wires.
  logic tick;
  logic sync_bit;
  logic filt;
  logic start_seen;
  logic in_idle;

  orx_tick_gen #(
    .CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVS(OVS), .ACC_W(ACC_W)
  ) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  orx_line_front u_front (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .sync_bit(sync_bit), .filt(filt)
  );

  orx_frame_fsm #(
    .OVS(OVS), .DATA_W(DATA_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .filt(filt),
    .start_seen(start_seen), .in_idle(in_idle),
    .rx_byte(rx_byte), .byte_valid(byte_valid), .frame_err(frame_err)
  );

  orx_gap_timer #(
    .OVS(OVS), .GAP_BITS(GAP_BITS)
  ) u_gap (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_idle(in_idle), .filt(filt),
    .start_seen(start_seen), .byte_valid(byte_valid), .pkt_end(pkt_end)
  );
endmodule

// File: rtl/orx_uart_rx_chk.sv
module orx_uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              sync_bit,
  input logic              filt,
  input logic [DATA_W-1:0] rx_byte,
  input logic              byte_valid,
  input logic              frame_err,
  input logic              pkt_end
);
  // R3: the filtered level only rises after a space sample.
  a_r3_rise_needs_space: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt) |-> $past(sync_bit));

  // R6: single-cycle valid pulse, issued on a tick edge.
  a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
  a_r6_valid_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(tick));

  // R6: output byte moves only together with the valid pulse.
  a_r6_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> byte_valid);

  // R7: error and valid never coincide; error lasts one cycle.
  a_r7_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && frame_err));
  a_r7_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  // R9: packet end comes from a tick on an idle filtered line, one cycle long.
  a_r9_eop_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> ($past(tick) && !$past(filt)));
  a_r9_eop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> !pkt_end);
endmodule

bind orx_uart_rx orx_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sync_bit(sync_bit), .filt(filt),
  .rx_byte(rx_byte), .byte_valid(byte_valid), .frame_err(frame_err),
  .pkt_end(pkt_end)
);

// File: tb/orx_uart_rx_test.sv
module orx_uart_rx_test;
  localparam int BITC = 32;   // clocks per bit with the chosen rates (R2)
  localparam int TCK  = 4;    // clocks per oversample tick

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] rx_byte;
  logic       byte_valid, frame_err, pkt_end;

  orx_uart_rx #(
    .CLK_HZ(200_000_000), .BAUD(6_250_000), .ACC_W(8), .OVS(8),
    .DATA_W(8), .GAP_BITS(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_byte(rx_byte),
    .byte_valid(byte_valid), .frame_err(frame_err), .pkt_end(pkt_end)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0, n_errs = 0;
  int m_checks = 0, m_errs = 0;
  int nvalid = 0, nerr = 0, neop = 0, n_sent = 0;
  logic [7:0] exp_q [0:511];
  logic [7:0] last_good = 8'h00;
  logic bv_prev = 1'b0;
  bit   done = 1'b0;

  // Port monitor, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid) begin
        m_checks++;
        if (nvalid >= n_sent || rx_byte !== exp_q[nvalid]) begin
          m_errs++;
          $display("FAIL R5 byte %0d: actual=%02h expected=%02h", nvalid, rx_byte,
                   (nvalid < n_sent) ? exp_q[nvalid] : 8'hxx);
        end
        nvalid++;
      end
      if (byte_valid && bv_prev) begin
        m_checks++; m_errs++;
        $display("FAIL R6 valid wider than one clock: actual=2 expected=1");
      end
      if (byte_valid && frame_err) begin
        m_checks++; m_errs++;
        $display("FAIL R7 valid and error together: actual=1 expected=0");
      end
      if (frame_err) nerr++;
      if (pkt_end) neop++;
      bv_prev = byte_valid;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_frame(input logic [7:0] b, input bit good);
    if (good) begin
      exp_q[n_sent] = b;
      n_sent++;
      last_good = b;
    end
    hold(1'b0, BITC);
    for (int i = 0; i < 8; i++) hold(b[i], BITC);
    hold(good ? 1'b1 : 1'b0, BITC);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs + m_errs, n_checks + m_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int p_v, p_e, p_o;
    // R1: reset values
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(rx_byte == 8'h00, "R1 rx_byte in reset", rx_byte, 0);
    chk({byte_valid, frame_err, pkt_end} == 3'b000, "R1 pulses in reset",
        {byte_valid, frame_err, pkt_end}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    hold(1'b1, 12 * BITC);
    chk(nvalid + nerr + neop == 0, "R1 idle line after reset", nvalid + nerr + neop, 0);
    chk(rx_byte == 8'h00, "R1 rx_byte after reset", rx_byte, 0);

    // R2 R5 R11: every byte value, frames back to back
    for (int i = 0; i < 256; i++) send_frame(i[7:0], 1'b1);
    hold(1'b1, BITC);
    chk(nvalid == 256, "R11 back-to-back sweep count", nvalid, 256);
    chk(neop == 0, "R9 no pkt_end in zero gaps", neop, 0);
    hold(1'b1, 4 * BITC);
    chk(neop == 1, "R9 pkt_end after quiet line", neop, 1);
    @(negedge clk);
    chk(rx_byte == 8'hFF, "R6 rx_byte holds last byte", rx_byte, 8'hFF);
    @(posedge clk); #1;

    // R9: one-bit gap is too short, long gap fires once
    p_o = neop;
    send_frame(8'h5A, 1'b1);
    hold(1'b1, BITC);
    send_frame(8'hC3, 1'b1);
    chk(neop == p_o, "R9 one-bit gap gives no pkt_end", neop, p_o);
    hold(1'b1, 8 * BITC);
    chk(neop == p_o + 1, "R9 single pkt_end per quiet spell", neop, p_o + 1);

    // R7 R10: stop bit as space
    p_v = nvalid; p_e = nerr; p_o = neop;
    send_frame(8'h3C, 1'b0);
    hold(1'b1, 6 * BITC);
    chk(nerr == p_e + 1, "R7 frame error pulse", nerr, p_e + 1);
    chk(nvalid == p_v, "R7 no valid on bad stop", nvalid, p_v);
    @(negedge clk);
    chk(rx_byte == last_good, "R7 rx_byte kept", rx_byte, last_good);
    @(posedge clk); #1;
    chk(neop == p_o, "R10 no pkt_end after errored frame only", neop, p_o);

    // R8: long break, then a normal byte
    p_v = nvalid; p_e = nerr;
    hold(1'b0, 20 * BITC);
    hold(1'b1, 3 * BITC);
    chk(nerr == p_e + 1, "R8 break gives one error", nerr, p_e + 1);
    chk(nvalid == p_v, "R8 break gives no byte", nvalid, p_v);
    send_frame(8'h81, 1'b1);
    hold(1'b1, BITC);
    chk(nvalid == p_v + 1, "R8 byte after break", nvalid, p_v + 1);

    // R3: 2-tick spike ignored
    hold(1'b1, 4 * BITC);
    p_v = nvalid; p_e = nerr;
    hold(1'b0, 2 * TCK);
    hold(1'b1, 4 * BITC);
    chk(nvalid == p_v && nerr == p_e, "R3 short spike ignored",
        nvalid + nerr, p_v + p_e);
    send_frame(8'hA5, 1'b1);
    hold(1'b1, BITC);
    chk(nvalid == p_v + 1, "R3 byte after spike", nvalid, p_v + 1);

    // R4: 3-tick space passes filter, fails start check
    hold(1'b1, 4 * BITC);
    p_v = nvalid; p_e = nerr;
    hold(1'b0, 3 * TCK);
    hold(1'b1, 4 * BITC);
    chk(nvalid == p_v && nerr == p_e, "R4 false start ignored",
        nvalid + nerr, p_v + p_e);
    send_frame(8'h96, 1'b1);
    hold(1'b1, BITC);
    chk(nvalid == p_v + 1, "R4 byte after false start", nvalid, p_v + 1);
    @(negedge clk);
    chk(rx_byte == 8'h96, "R5 last byte value", rx_byte, 8'h96);

    chk(nvalid == n_sent, "R11 total bytes", nvalid, n_sent);
    finish_run();
  end
endmodule